// File: doc/BRIEF.md
# Fourth-Order CIC Decimating Filter

This block is a four-stage cascaded integrator-comb filter that reduces the rate of a stream of signed 12-bit converter samples by an integer ratio M. It accepts a sample on each clock where `in_valid` is high, at up to 26 MHz, and emits one filtered sample for every M accepted samples. The response is (1/M)·((1 − z^−M)/(1 − z^−1))^4, built as four integrators at the input rate and four single-delay combs at the output rate.

The datapath is 32 bits wide. Before the first integrator, the input is shifted arithmetically right by (20 − S) bits, where S is the scale setting. For every legal pair of M and S, the full M^4 gain then fits in the register width. The output is bits [31:20] of the last comb, so S = 20 with M = 32 gives unity gain. Any difference between the requested settings and the settings in use starts a one-cycle synchronous clear. The clear zeroes all filter state and the sample count and then applies the new settings.

Top module: `cic4_decim`

## Requirements
- R1: `out_valid` rises for exactly one clock in the cycle after every M-th accepted sample (`in_valid` high, no clear in progress). Counting starts at reset or at a clear. Idle cycles do not advance the count.
- R2: The ratio input is clamped into 8..32. A request below 8 acts as 8 and a request above 32 acts as 32.
- R3: For a constant input x held for at least 4·M samples, from the fifth output on, the output equals floor((x >>> (20 − S))·M^4 / 2^20). Examples: M=32,S=20,x=1000 gives 1000; M=16,S=20,x=−1600 gives −100; M=24,S=18,x=−1000 gives −80.
- R4: The scale input is clamped into 12..20. The input shift is arithmetic: M=32,S=12,x=−2048 gives −8.
- R5: A change of the clamped ratio or scale costs one clear cycle. In that cycle the input sample is discarded and `out_valid` stays low in the following cycle. Counting restarts so that M further accepted samples produce the next output.
- R6: While reset is high, and in the cycle after it, `out_valid` and `out_data` are 0.
- R7: After a clear, filter history is gone. The first output for constant x equals floor((x >>> (20 − S))·C(M+3,4) / 2^20). For M=32,S=20,x=2047 this is 102.
- R8: The extremes x=2047 and x=−2048 at M=32,S=20 pass through as 2047 and −2048 with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed input sample |
| cfg_ratio | input | 6 | Requested decimation ratio |
| cfg_scale | input | 5 | Requested scale setting |
| out_valid | output | 1 | One-clock output strobe |
| out_data | output | 12 | Signed decimated sample |

## Verification
The bench builds the block with its default 12-bit input and 32-bit internal width. At these values the full ratio range 8..32 and the scale range 12..20 can be reached directly, so both clamping edges and the exact 2^31 magnitude limit at M=32 are exercised. Steady-state values are worked out by hand from the gain formula. The transient after a clear is checked against the binomial first-output value, which makes any leftover history visible.

// File: rtl/cic4_pkg.sv
package cic4_pkg;
    localparam int DATA_W    = 12;
    localparam int SCALE_MIN = 12;
    localparam int SCALE_MAX = 20;
    localparam int RATIO_MIN = 8;
    localparam int RATIO_MAX = 32;
    localparam int N_STAGES  = 4;
    localparam int ACC_W     = DATA_W + SCALE_MAX;
    localparam int RATIO_W   = $clog2(RATIO_MAX + 1);
    localparam int SCALE_W   = $clog2(SCALE_MAX + 1);

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [SCALE_W-1:0] scale;
    } cfg_t;

    function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
        if (r < RATIO_W'(RATIO_MIN)) return RATIO_W'(RATIO_MIN);
        if (r > RATIO_W'(RATIO_MAX)) return RATIO_W'(RATIO_MAX);
        return r;
    endfunction

    function automatic logic [SCALE_W-1:0] clamp_scale(input logic [SCALE_W-1:0] s);
        if (s < SCALE_W'(SCALE_MIN)) return SCALE_W'(SCALE_MIN);
        if (s > SCALE_W'(SCALE_MAX)) return SCALE_W'(SCALE_MAX);
        return s;
    endfunction

    function automatic acc_t prescale(input sample_t x, input logic [SCALE_W-1:0] s);
        acc_t wide;
        wide = acc_t'(x);
        return wide >>> (SCALE_W'(SCALE_MAX) - s);
    endfunction
endpackage

// File: rtl/cic4_ctrl.sv
module cic4_ctrl
    import cic4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [RATIO_W-1:0] req_ratio,
    input  logic [SCALE_W-1:0] req_scale,
    output cfg_t               cfg_q,
    output logic               clr,
    output logic               acc_en,
    output logic               dec_en
);
    cfg_t               cfg_req;
    logic [RATIO_W-1:0] cnt;
    logic               last;

    always_comb begin
        cfg_req.ratio = clamp_ratio(req_ratio);
        cfg_req.scale = clamp_scale(req_scale);
    end

    assign clr    = (cfg_req != cfg_q);
    assign acc_en = in_valid && !clr;
    assign last   = (cnt == cfg_q.ratio - RATIO_W'(1));
    assign dec_en = acc_en && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_req;
            cnt   <= '0;
        end else if (clr) begin
            cfg_q <= cfg_req;
            cnt   <= '0;
        end else if (acc_en) begin
            cnt <= last ? '0 : cnt + RATIO_W'(1);
        end
    end

    AST_CFG_RANGE: assert property (@(posedge clk) disable iff (rst)
        cfg_q.ratio >= RATIO_W'(RATIO_MIN) && cfg_q.ratio <= RATIO_W'(RATIO_MAX)
        && cfg_q.scale >= SCALE_W'(SCALE_MIN) && cfg_q.scale <= SCALE_W'(SCALE_MAX)); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < cfg_q.ratio); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clr |=> $stable(cfg_q)); // R5
endmodule

// File: rtl/cic4_integ_chain.sv
module cic4_integ_chain
    import cic4_pkg::*;
#(
    parameter int STAGES = N_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  acc_t din,
    output acc_t dout
);
    acc_t acc [STAGES];
    acc_t nxt [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign nxt[k] = acc[k] + din;
        end else begin : g_rest
            assign nxt[k] = acc[k] + nxt[k-1];
        end
        always_ff @(posedge clk) begin
            if (rst || clr)  acc[k] <= '0;
            else if (en)     acc[k] <= nxt[k];
        end
    end

    assign dout = nxt[STAGES-1];
endmodule

// File: rtl/cic4_comb_chain.sv
module cic4_comb_chain
    import cic4_pkg::*;
#(
    parameter int STAGES = N_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  acc_t din,
    output acc_t dout
);
    acc_t dly [STAGES];
    acc_t stin [STAGES];
    acc_t diff [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign stin[k] = din;
        end else begin : g_rest
            assign stin[k] = diff[k-1];
        end
        assign diff[k] = stin[k] - dly[k];
        always_ff @(posedge clk) begin
            if (rst || clr)  dly[k] <= '0;
            else if (en)     dly[k] <= stin[k];
        end
    end

    assign dout = diff[STAGES-1];
endmodule

// File: rtl/cic4_decim.sv
module cic4_decim
    import cic4_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [SCALE_W-1:0] cfg_scale,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data
);
    cfg_t cfg_q;
    logic clr, acc_en, dec_en;
    acc_t shifted, integ_out, comb_out;

    cic4_ctrl u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .req_ratio(cfg_ratio), .req_scale(cfg_scale),
        .cfg_q(cfg_q), .clr(clr), .acc_en(acc_en), .dec_en(dec_en)
    );

    assign shifted = prescale(sample_t'(in_data), cfg_q.scale);

    cic4_integ_chain #(.STAGES(N_STAGES)) u_integ (
        .clk(clk), .rst(rst), .clr(clr), .en(acc_en),
        .din(shifted), .dout(integ_out)
    );

    cic4_comb_chain #(.STAGES(N_STAGES)) u_comb (
        .clk(clk), .rst(rst), .clr(clr), .en(dec_en),
        .din(integ_out), .dout(comb_out)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= dec_en;
            if (dec_en) out_data <= comb_out[ACC_W-1 -: DATA_W];
        end
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R1
    AST_QUIET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> !out_valid); // R5
    AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
endmodule

// File: tb/cic4_decim_tb_top.sv
module cic4_decim_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    // ratio, scale, input, expected steady output, requirement tag
    localparam int VEC [NVEC][5] = '{
        '{32, 20,  1000,  1000, 3},
        '{32, 20,  2047,  2047, 8},
        '{32, 20, -2048, -2048, 8},
        '{16, 20, -1600,  -100, 3},
        '{ 8, 20,  2047,     7, 3},
        '{20, 20,   300,    45, 3},
        '{24, 18, -1000,   -80, 3},
        '{32, 12,  1000,     3, 4},
        '{32, 12, -2048,    -8, 4},
        '{40, 20,  1000,  1000, 2},
        '{ 3, 20,  2047,     7, 2},
        '{32, 25,  1000,  1000, 4},
        '{32,  3,  1000,     3, 4}
    };

    logic clk = 0, rst = 1, in_valid = 0;
    logic [11:0] in_data = '0;
    logic [5:0]  cfg_ratio = 6'd32;
    logic [4:0]  cfg_scale = 5'd20;
    logic out_valid;
    logic [11:0] out_data;

    int checks = 0, errors = 0, out_count = 0, pulse_err = 0;
    logic signed [11:0] last_out = '0;
    logic prev_valid = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cic4_decim dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .cfg_ratio(cfg_ratio), .cfg_scale(cfg_scale),
        .out_valid(out_valid), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            out_count++;
            last_out = out_data;
            if (prev_valid) pulse_err++;
        end
        prev_valid = out_valid;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int r, input int s);
        @(negedge clk);
        cfg_ratio = 6'(r); cfg_scale = 5'(s); in_valid = 0;
        @(negedge clk);
    endtask

    task automatic feed(input int x, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            in_valid = 1; in_data = 12'(x);
            @(negedge clk);
            if (gaps) begin in_valid = 0; @(negedge clk); end
        end
        in_valid = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R6 valid in reset", int'(out_valid), 0);
        check("R6 data in reset", int'(out_data), 0);
        rst = 0;
        @(negedge clk);
        check("R6 valid after reset", int'(out_valid), 0);
        check("R6 data after reset", int'(out_data), 0);

        // table walk: R2 R3 R4 R8
        for (int v = 0; v < NVEC; v++) begin
            int m;
            m = VEC[v][0] < 8 ? 8 : (VEC[v][0] > 32 ? 32 : VEC[v][0]);
            set_cfg(VEC[v][0], VEC[v][1]);
            out_count = 0;
            feed(VEC[v][2], 5 * m, 0);
            check($sformatf("R%0d count vec %0d", VEC[v][4], v), out_count, 5);
            check($sformatf("R%0d value vec %0d", VEC[v][4], v), int'(last_out), VEC[v][3]);
        end

        // R1: gapped input, M=8
        set_cfg(8, 20);
        out_count = 0;
        feed(100, 7, 1);
        check("R1 no output before 8th sample", out_count, 0);
        feed(100, 1, 1);
        check("R1 output on 8th sample", out_count, 1);
        feed(100, 8, 1);
        check("R1 output on 16th sample", out_count, 2);

        // R5: sample in clear cycle is dropped
        @(negedge clk);
        cfg_ratio = 6'd16; in_valid = 1; in_data = 12'd5;
        @(negedge clk);
        out_count = 0;
        feed(5, 15, 0);
        check("R5 no output after 16 offered incl clear", out_count, 0);
        feed(5, 1, 0);
        check("R5 output on next sample", out_count, 1);

        // R7: history cleared, first output transient
        set_cfg(16, 20);
        feed(-1500, 40, 0);
        set_cfg(32, 20);
        out_count = 0;
        feed(2047, 32, 0);
        check("R7 first output count", out_count, 1);
        check("R7 first output value", int'(last_out), 102);

        // R6: mid-run reset restarts count
        feed(2047, 10, 0);
        @(negedge clk); rst = 1;
        @(negedge clk);
        check("R6 valid during reset", int'(out_valid), 0);
        rst = 0;
        @(negedge clk);
        check("R6 data after reset", int'(out_data), 0);
        out_count = 0;
        feed(50, 31, 0);
        check("R6 count restarts", out_count, 0);
        feed(50, 1, 0);
        check("R6 output on 32nd sample", out_count, 1);

        check("R1 single-cycle pulses", pulse_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule